// File: doc/BRIEF.md
# System Control Port Register

This block is a single byte-wide control register that sits on a simple I/O-mapped peripheral bus at port address 0x92. Software writes a whole byte to it and can read the byte back. Two of its bits drive system functions:

- Bit 1 drives an enable for the address-line-20 gate. It holds that level for as long as the register keeps the bit.
- Bit 0 is a reset trigger. Changing it from 0 to 1 sends a one-clock reset request to the system reset logic.

There are two reset inputs, and they have different scopes. The power-on reset clears the whole register. The device reset clears only the trigger bit. Because bits 7..1 survive a device reset, the gate enable keeps its level across it.

The register's update is a small state machine driven by an operation code:

- **OP_HOLD**: keep the stored value.
- **OP_LOAD**: take the write byte.
- **OP_CLR0**: clear bit 0 only.

The request generator has two named states:

- **REQ_IDLE**: `rst_req` is low. It moves to REQ_FIRE on a qualifying write and otherwise stays.
- **REQ_FIRE**: `rst_req` is high. It returns to REQ_IDLE on the next edge unless another qualifying write arrives.

A second qualifying write can only follow after bit 0 has gone back to 0, so in practice REQ_FIRE always returns to REQ_IDLE.

Top module: `sysctl_port`

## Requirements
- R1: When `por` is high at a clock edge, the register becomes 0x00 and `gate_a20` and `rst_req` are low after that edge.
- R2: A write with `bus_addr` equal to 0x0092 stores all 8 bits of `bus_wdata`. A read at 0x0092 returns the stored byte on `bus_rdata` in the same cycle, bit 0 included.
- R3: A write to any other address leaves the register unchanged. `bus_rdata` is 0x00 whenever no read at 0x0092 is in progress.
- R4: `gate_a20` equals bit 1 of the stored byte. It takes the new value right after the clock edge that captures the write.
- R5: `rst_req` is high for exactly the one cycle after the edge that captures a port write whose bit 0 is 1 while the stored bit 0 was 0.
- R6: A port write with bit 0 equal to 0 raises no request. Neither does a port write with bit 0 equal to 1 while the stored bit 0 is already 1.
- R7: `dev_rst` without a port write clears bit 0 only. Bits 7..1, and therefore `gate_a20`, keep their values.
- R8: When a port write and `dev_rst` occur in the same cycle, the write is stored in full. The request is judged against bit 0 as stored before the write.
- R9: After `dev_rst` has cleared bit 0, a write that sets bit 0 raises a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous active-high power-on reset, clears the whole register |
| dev_rst | input | 1 | Synchronous active-high device reset, clears bit 0 only |
| bus_addr | input | 16 | I/O address of the current access |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data, stored byte when a read hits the port, otherwise 0x00 |
| gate_a20 | output | 1 | Address-line-20 gate enable, equal to stored bit 1 |
| rst_req | output | 1 | One-cycle system reset request pulse |

## Verification
The assertions assume that every input is stable at each rising clock edge, since they sample the bus as a registered design does. They also assume that `por` is held high through the first edge, so that the register's contents are defined before any rule about past values applies. The bench changes inputs only on the falling edge and raises `por` before the first rising edge. It sends roughly half of its random accesses to the port address, so that writes, reads and device resets collide often, including write plus device reset in the same cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int TRIG_BIT  = 0;
    localparam int GATE_BIT  = 1;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_CLR0 = 2'd2
    } store_op_e;

    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_FIRE = 1'b1
    } req_state_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
    parameter int                  AW   = 16,
    parameter logic [AW-1:0]       BASE = 16'h0092
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    output logic          wr_hit,
    output logic          rd_hit
);
    logic sel;

    always_comb begin
        sel    = (addr == BASE);
        wr_hit = sel && wr;
        rd_hit = sel && rd;
    end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int DW = 8,
    parameter int TB = 0
) (
    input  logic          clk,
    input  logic          por,
    input  logic          dev_rst,
    input  logic          wr_hit,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] value_q
);
    store_op_e     op;
    logic [DW-1:0] value_d;

    // Write has priority over the device reset.
    always_comb begin
        if (wr_hit)       op = OP_LOAD;
        else if (dev_rst) op = OP_CLR0;
        else              op = OP_HOLD;
    end

    always_comb begin
        value_d = value_q;
        unique case (op)
            OP_LOAD: value_d = wdata;
            OP_CLR0: value_d[TB] = 1'b0;
            default: value_d = value_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por) value_q <= '0;
        else     value_q <= value_d;
    end
endmodule

// File: rtl/sysctl_reqgen.sv
module sysctl_reqgen
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic por,
    input  logic wr_hit,
    input  logic new_trig,
    input  logic old_trig,
    output logic req
);
    req_state_e state_q, state_d;
    logic       qualify;

    always_comb begin
        qualify = wr_hit && new_trig && !old_trig;
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: state_d = qualify ? REQ_FIRE : REQ_IDLE;
            REQ_FIRE: state_d = qualify ? REQ_FIRE : REQ_IDLE;
            default:  state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por) state_q <= REQ_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        req = (state_q == REQ_FIRE);
    end
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
    import sysctl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092
) (
    input  logic              clk,
    input  logic              por,
    input  logic              dev_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              gate_a20,
    output logic              rst_req
);
    logic              wr_hit;
    logic              rd_hit;
    logic [DATA_W-1:0] store_q;

    sysctl_decode #(.AW(ADDR_W), .BASE(PORT_ADDR)) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    sysctl_store #(.DW(DATA_W), .TB(TRIG_BIT)) u_store (
        .clk     (clk),
        .por     (por),
        .dev_rst (dev_rst),
        .wr_hit  (wr_hit),
        .wdata   (bus_wdata),
        .value_q (store_q)
    );

    sysctl_reqgen u_req (
        .clk      (clk),
        .por      (por),
        .wr_hit   (wr_hit),
        .new_trig (bus_wdata[TRIG_BIT]),
        .old_trig (store_q[TRIG_BIT]),
        .req      (rst_req)
    );

    always_comb begin
        bus_rdata = rd_hit ? store_q : '0;
        gate_a20  = store_q[GATE_BIT];
    end
endmodule

// File: rtl/sysctl_port_chk.sv
module sysctl_port_chk (
    input logic       clk,
    input logic       por,
    input logic       dev_rst,
    input logic       wr_hit,
    input logic       rd_hit,
    input logic [7:0] wdata,
    input logic [7:0] stored,
    input logic [7:0] rdata,
    input logic       gate_a20,
    input logic       rst_req
);
    // R1
    por_clears_chk: assert property (@(posedge clk) por |=> (stored == 8'h00) && !rst_req && !gate_a20);

    // R2
    write_stores_chk: assert property (@(posedge clk) disable iff (por) wr_hit |=> stored == $past(wdata));

    // R3
    miss_holds_chk: assert property (@(posedge clk) disable iff (por) (!wr_hit && !dev_rst) |=> $stable(stored));

    // R3
    rdata_idle_chk: assert property (@(posedge clk) disable iff (por) !rd_hit |-> rdata == 8'h00);

    // R4
    gate_follows_chk: assert property (@(posedge clk) disable iff (por) wr_hit |=> gate_a20 == $past(wdata[1]));

    // R5
    req_cause_chk: assert property (@(posedge clk) disable iff (por) rst_req |-> ($past(wr_hit) && $past(wdata[0]) && !$past(stored[0])));

    // R5
    req_single_chk: assert property (@(posedge clk) disable iff (por) rst_req |=> !rst_req);

    // R6
    no_rereq_chk: assert property (@(posedge clk) disable iff (por) (wr_hit && stored[0]) |=> !rst_req);

    // R7
    devrst_scope_chk: assert property (@(posedge clk) disable iff (por) (dev_rst && !wr_hit) |=> !stored[0] && stored[7:1] == $past(stored[7:1]));
endmodule

bind sysctl_port sysctl_port_chk u_chk (
    .clk      (clk),
    .por      (por),
    .dev_rst  (dev_rst),
    .wr_hit   (wr_hit),
    .rd_hit   (rd_hit),
    .wdata    (bus_wdata),
    .stored   (store_q),
    .rdata    (bus_rdata),
    .gate_a20 (gate_a20),
    .rst_req  (rst_req)
);

// File: tb/test_sysctl_port.sv
module test_sysctl_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] PORT = 16'h0092;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        dev_rst = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        gate_a20;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_reg = 8'h00;
    logic       m_req = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_port i_sysctl_port (
        .clk       (clk),
        .por       (por),
        .dev_rst   (dev_rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gate_a20  (gate_a20),
        .rst_req   (rst_req)
    );

    function automatic logic [7:0] next_reg(logic [7:0] cur, logic p, logic hit_w,
                                            logic dr, logic [7:0] wd);
        if (p)          return 8'h00;
        else if (hit_w) return wd;
        else if (dr)    return {cur[7:1], 1'b0};
        return cur;
    endfunction

    function automatic logic next_req(logic [7:0] cur, logic p, logic hit_w, logic [7:0] wd);
        return !p && hit_w && wd[0] && !cur[0];
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at negedge, check read data, step one edge, check outputs.
    task automatic cyc(logic [15:0] a, logic w, logic r, logic [7:0] d, logic dr, string tag);
        logic hit_w;
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; dev_rst = dr;
        #1;
        check({tag, "/rdata R2 R3"}, bus_rdata, (r && a == PORT) ? m_reg : 8'h00);
        hit_w = w && (a == PORT);
        @(posedge clk);
        m_req = next_req(m_reg, por, hit_w, d);
        m_reg = next_reg(m_reg, por, hit_w, dr, d);
        @(negedge clk);
        check({tag, "/gate R4"}, {7'b0, gate_a20}, {7'b0, m_reg[1]});
        check({tag, "/req R5 R6"}, {7'b0, rst_req}, {7'b0, m_req});
        bus_wr = 0; bus_rd = 0; dev_rst = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        cyc(16'h0, 0, 0, 8'h0, 0, "R1 por");
        por = 0;
        check("R1 reset gate", {7'b0, gate_a20}, 8'h00);
        check("R1 reset req", {7'b0, rst_req}, 8'h00);
        cyc(PORT, 0, 1, 8'h0, 0, "R1 readback");
        // R2 full byte store and readback
        cyc(PORT, 1, 0, 8'hA6, 0, "R2 write");
        cyc(PORT, 0, 1, 8'h0, 0, "R2 read");
        // R3 miss write ignored, visible on read
        cyc(16'h0093, 1, 0, 8'h5B, 0, "R3 miss");
        cyc(16'h0091, 0, 1, 8'h0, 0, "R3 miss read");
        cyc(PORT, 0, 1, 8'h0, 0, "R3 readback");
        // R5 rising edge of bit 0
        cyc(PORT, 1, 0, 8'h03, 0, "R5 fire");
        cyc(PORT, 0, 0, 8'h0, 0, "R5 one cycle");
        // R6 repeat write with bit 0 already set
        cyc(PORT, 1, 0, 8'h03, 0, "R6 no refire");
        cyc(PORT, 1, 0, 8'h02, 0, "R6 clear by write");
        // R7 device reset keeps bits 7..1
        cyc(PORT, 1, 0, 8'hF3, 0, "R7 setup");
        cyc(PORT, 0, 0, 8'h0, 1, "R7 devrst");
        cyc(PORT, 0, 1, 8'h0, 0, "R7 readback");
        // R9 re-arm after device reset
        cyc(PORT, 1, 0, 8'hF3, 0, "R9 refire");
        // R8 write plus device reset, bit 0 already 1: no request
        cyc(PORT, 1, 0, 8'h11, 1, "R8 collide high");
        cyc(PORT, 0, 1, 8'h0, 0, "R8 readback");
        cyc(PORT, 0, 0, 8'h0, 1, "R8 clear");
        cyc(PORT, 1, 0, 8'h01, 1, "R8 collide fire");
        cyc(PORT, 0, 1, 8'h0, 0, "R8 readback2");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            a = ($urandom % 2) ? PORT : 16'($urandom);
            cyc(a, 1'($urandom), 1'($urandom), 8'($urandom), ($urandom % 4) == 0, "rand");
        end
        // R1 power-on reset mid-run
        por = 1;
        cyc(PORT, 0, 0, 8'h0, 0, "R1 por again");
        por = 0;
        cyc(PORT, 0, 1, 8'h0, 0, "R1 readback2");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule